// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Status

This block gathers the interrupt requests of one UART channel, selects the most urgent one that is pending and enabled, and presents it as an 8-bit interrupt status word together with an active-high interrupt output. Seven sources feed it. Four are level requests from the surrounding channel: line status, receive time-out, receive data ready and modem status. Three are event pulses that the block holds in sticky flags: transmitter empty, received Xoff or special-character match, and deassertion of a flow-control line (CTS# or RTS#).

The status word is a combinational view of the current requests and the held flags. A read strobe clears only the held flag whose source the word is showing in that cycle. Level sources stay visible while their condition holds. The two extended sources (character match and flow-control change) only take part when the enhanced-feature enable is high. Bits 7:6 of the word mirror the FIFO-enable flag.

Top module: `uart_irq_prio`

## Requirements
- R1: While reset is low and right after it, all held flags are clear, `irq_o` is low and `isr_o[5:0]` is 6'b000001.
- R2: `isr_o[5:0]` shows the highest-priority enabled pending source, highest first: line status 6'b000110, receive time-out 6'b001100, receive data ready 6'b000100, transmitter empty 6'b000010, modem status 6'b000000, character match 6'b010000, flow-control change 6'b100000; with none pending it is 6'b000001.
- R3: `isr_o[7:6]` is 2'b11 when `fifo_en_i` is high and 2'b00 when it is low.
- R4: `irq_o` is high exactly when some enabled source is pending, which is when `isr_o[0]` is 0.
- R5: A source whose bit in `src_en_i` is 0 is never reported and does not raise `irq_o`. Bit order of `src_en_i`: 0 line status, 1 receive time-out, 2 receive data ready, 3 transmitter empty, 4 modem status, 5 character match, 6 flow-control change.
- R6: With `efe_i` low the character-match and flow-control sources are masked, so `isr_o[5:4]` is 2'b00. Their flags still latch and appear once `efe_i` rises.
- R7: A read (`isr_rd_i` high in a cycle) clears only the held flag of the source shown in that cycle. Level sources and other held flags are unaffected.
- R8: The transmitter-empty flag is set one cycle after a `tx_empty_i` pulse. It is cleared by a read that shows it, or by a `tx_write_i` pulse.
- R9: An Xoff match (`xoff_hit_i`) is cleared only by a read showing the character-match source. A special-character match (`spc_hit_i`) is cleared by such a read, or by the next `rx_char_i` pulse.
- R10: A `flow_drop_i` pulse sets the flow-control flag, which a read showing code 6'b100000 clears.
- R11: When a set pulse and a clear of the same flag meet in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| src_en_i | input | 7 | Per-source enable |
| efe_i | input | 1 | Enhanced-feature enable for the extended sources |
| fifo_en_i | input | 1 | FIFO-enable flag, shown in bits 7:6 |
| line_req_i | input | 1 | Line status request (level) |
| rxto_req_i | input | 1 | Receive time-out request (level) |
| rxrdy_req_i | input | 1 | Receive data ready request (level) |
| modem_req_i | input | 1 | Modem status request (level) |
| tx_empty_i | input | 1 | Transmit holding path emptied (pulse) |
| tx_write_i | input | 1 | Transmitter written (pulse) |
| xoff_hit_i | input | 1 | Received character matched Xoff (pulse) |
| spc_hit_i | input | 1 | Received character matched special character (pulse) |
| flow_drop_i | input | 1 | CTS# or RTS# deasserted (pulse) |
| rx_char_i | input | 1 | A character was received (pulse) |
| isr_rd_i | input | 1 | Status-word read strobe |
| isr_o | output | 8 | Interrupt status word |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The assertions assume that reset is held low from time zero and that every input is a clean synchronous level that changes only between clock edges. They also assume a read strobe is sampled in the same cycle as the word it reads. Nothing else about pulse widths or spacing is assumed: the flag properties are written for any mix of set and clear in one cycle. The random stimulus therefore draws each event pulse and the read strobe independently every cycle, so that collisions of set and clear occur often. Directed sequences cover the orderings the requirements name: a masked flag that later shows, a special character that is cleared by reception, and an Xoff match that reception does not clear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned NUM_SRC  = 7;
    localparam int unsigned SRC_W    = $clog2(NUM_SRC);
    localparam int unsigned CODE_W   = 6;
    localparam int unsigned STAT_W   = 8;
    localparam int unsigned FIRST_EXT = 5;

    typedef enum logic [SRC_W-1:0] {
        SRC_LINE  = 3'd0,
        SRC_RXTO  = 3'd1,
        SRC_RXRDY = 3'd2,
        SRC_TXMT  = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_CHAR  = 3'd5,
        SRC_FLOW  = 3'd6
    } src_e;

    localparam logic [CODE_W-1:0] CODE_NONE = 6'b000001;

    typedef struct packed {
        logic tx;
        logic xoff;
        logic spc;
        logic flow;
    } sticky_t;

    function automatic logic [CODE_W-1:0] src_code(input logic [SRC_W-1:0] s);
        case (s)
            SRC_LINE:  src_code = 6'b000110;
            SRC_RXTO:  src_code = 6'b001100;
            SRC_RXRDY: src_code = 6'b000100;
            SRC_TXMT:  src_code = 6'b000010;
            SRC_MODEM: src_code = 6'b000000;
            SRC_CHAR:  src_code = 6'b010000;
            SRC_FLOW:  src_code = 6'b100000;
            default:   src_code = CODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_arb.sv
module uart_irq_arb #(
    parameter int unsigned N   = 7,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  pend_i,
    output logic [IW-1:0] sel_o,
    output logic          any_o
);

    // Lowest index wins: walk from the bottom of the priority list upward.
    always_comb begin
        sel_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                sel_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
    import uart_irq_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    tx_empty_i,
    input  logic    tx_write_i,
    input  logic    xoff_hit_i,
    input  logic    spc_hit_i,
    input  logic    flow_drop_i,
    input  logic    rx_char_i,
    input  logic    clr_tx_i,
    input  logic    clr_char_i,
    input  logic    clr_flow_i,
    output sticky_t flags_o
);

    sticky_t flags_d, flags_q;

    // Set terms are OR-ed last so a set always beats a clear in the same cycle.
    always_comb begin
        flags_d      = flags_q;
        flags_d.tx   = tx_empty_i  | (flags_q.tx   & ~clr_tx_i & ~tx_write_i);
        flags_d.xoff = xoff_hit_i  | (flags_q.xoff & ~clr_char_i);
        flags_d.spc  = spc_hit_i   | (flags_q.spc  & ~clr_char_i & ~rx_char_i);
        flags_d.flow = flow_drop_i | (flags_q.flow & ~clr_flow_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               efe_i,
    input  logic               fifo_en_i,
    input  logic               line_req_i,
    input  logic               rxto_req_i,
    input  logic               rxrdy_req_i,
    input  logic               modem_req_i,
    input  logic               tx_empty_i,
    input  logic               tx_write_i,
    input  logic               xoff_hit_i,
    input  logic               spc_hit_i,
    input  logic               flow_drop_i,
    input  logic               rx_char_i,
    input  logic               isr_rd_i,
    output logic [STAT_W-1:0]  isr_o,
    output logic               irq_o
);

    sticky_t            sticky_q;
    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] pend;
    logic [SRC_W-1:0]   sel;
    logic               any;
    logic               rd_hit;

    assign raw_req[SRC_LINE]  = line_req_i;
    assign raw_req[SRC_RXTO]  = rxto_req_i;
    assign raw_req[SRC_RXRDY] = rxrdy_req_i;
    assign raw_req[SRC_TXMT]  = sticky_q.tx;
    assign raw_req[SRC_MODEM] = modem_req_i;
    assign raw_req[SRC_CHAR]  = sticky_q.xoff | sticky_q.spc;
    assign raw_req[SRC_FLOW]  = sticky_q.flow;

    // Classic sources need only their enable; extended ones also need efe_i.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_mask
        if (g >= FIRST_EXT) begin : g_ext
            assign pend[g] = raw_req[g] & src_en_i[g] & efe_i;
        end else begin : g_base
            assign pend[g] = raw_req[g] & src_en_i[g];
        end
    end

    uart_irq_arb #(.N(NUM_SRC)) u_arb (
        .pend_i (pend),
        .sel_o  (sel),
        .any_o  (any)
    );

    assign rd_hit = isr_rd_i & any;

    uart_irq_flags u_flags (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tx_empty_i  (tx_empty_i),
        .tx_write_i  (tx_write_i),
        .xoff_hit_i  (xoff_hit_i),
        .spc_hit_i   (spc_hit_i),
        .flow_drop_i (flow_drop_i),
        .rx_char_i   (rx_char_i),
        .clr_tx_i    (rd_hit & (sel == SRC_TXMT)),
        .clr_char_i  (rd_hit & (sel == SRC_CHAR)),
        .clr_flow_i  (rd_hit & (sel == SRC_FLOW)),
        .flags_o     (sticky_q)
    );

    assign isr_o = {{2{fifo_en_i}}, any ? src_code(sel) : CODE_NONE};
    assign irq_o = any;

endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk
    import uart_irq_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              efe_i,
    input logic              fifo_en_i,
    input logic              tx_empty_i,
    input logic              tx_write_i,
    input logic              xoff_hit_i,
    input logic              spc_hit_i,
    input logic              flow_drop_i,
    input logic              rx_char_i,
    input logic              isr_rd_i,
    input logic [STAT_W-1:0] isr_o,
    input logic              irq_o,
    input sticky_t           sticky_q
);

    p_fifo_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        isr_o[7:6] == {2{fifo_en_i}});

    p_irq_bit0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == !isr_o[0]);

    p_ext_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !efe_i |-> isr_o[5:4] == 2'b00);

    p_tx_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_empty_i |=> sticky_q.tx);

    p_tx_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_write_i && !tx_empty_i |=> !sticky_q.tx);

    p_spc_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_char_i && !spc_hit_i |=> !sticky_q.spc);

    p_xoff_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !isr_rd_i && !xoff_hit_i |=> sticky_q.xoff == $past(sticky_q.xoff));

    p_flow_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        isr_rd_i && isr_o[5:0] == 6'b100000 && !flow_drop_i |=> !sticky_q.flow);

    p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flow_drop_i && isr_rd_i |=> sticky_q.flow);

endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .efe_i       (efe_i),
    .fifo_en_i   (fifo_en_i),
    .tx_empty_i  (tx_empty_i),
    .tx_write_i  (tx_write_i),
    .xoff_hit_i  (xoff_hit_i),
    .spc_hit_i   (spc_hit_i),
    .flow_drop_i (flow_drop_i),
    .rx_char_i   (rx_char_i),
    .isr_rd_i    (isr_rd_i),
    .isr_o       (isr_o),
    .irq_o       (irq_o),
    .sticky_q    (sticky_q)
);

// File: tb/uart_irq_prio_bench.sv
module uart_irq_prio_bench;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [6:0] src_en_i = 7'h7F;
    logic       efe_i = 1'b1, fifo_en_i = 1'b0;
    logic       line_req_i = 1'b0, rxto_req_i = 1'b0, rxrdy_req_i = 1'b0, modem_req_i = 1'b0;
    logic       tx_empty_i = 1'b0, tx_write_i = 1'b0, xoff_hit_i = 1'b0, spc_hit_i = 1'b0;
    logic       flow_drop_i = 1'b0, rx_char_i = 1'b0, isr_rd_i = 1'b0;
    logic [7:0] isr_o;
    logic       irq_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Bench-side model of the held flags
    bit m_tx = 0, m_xoff = 0, m_spc = 0, m_flow = 0;

    always #5 clk_i = ~clk_i;

    uart_irq_prio u_uart_irq_prio (.*);

    function automatic logic [6:0] exp_pend();
        logic [6:0] p;
        p[0] = line_req_i;
        p[1] = rxto_req_i;
        p[2] = rxrdy_req_i;
        p[3] = m_tx;
        p[4] = modem_req_i;
        p[5] = (m_xoff | m_spc) & efe_i;
        p[6] = m_flow & efe_i;
        return p & src_en_i;
    endfunction

    function automatic int exp_sel();
        logic [6:0] p = exp_pend();
        for (int i = 0; i < 7; i++) if (p[i]) return i;
        return 7;
    endfunction

    function automatic logic [7:0] exp_isr();
        logic [5:0] c;
        case (exp_sel())
            0: c = 6'b000110;
            1: c = 6'b001100;
            2: c = 6'b000100;
            3: c = 6'b000010;
            4: c = 6'b000000;
            5: c = 6'b010000;
            6: c = 6'b100000;
            default: c = 6'b000001;
        endcase
        return {{2{fifo_en_i}}, c};
    endfunction

    // Check one cycle at the falling edge, advance the model, clear pulses.
    task automatic cyc(input string tag, input int want = -1);
        logic [7:0] e;
        int s;
        bit rd;
        @(negedge clk_i);
        e = exp_isr();
        tests++;
        if (isr_o !== e) begin
            fails++;
            $display("FAIL %s: isr_o=%h expected %h", tag, isr_o, e);
        end
        tests++;
        if (irq_o !== (exp_sel() != 7)) begin
            fails++;
            $display("FAIL R4: irq_o=%b expected %b", irq_o, exp_sel() != 7);
        end
        if (want >= 0) begin
            tests++;
            if (isr_o !== 8'(want)) begin
                fails++;
                $display("FAIL %s: isr_o=%h expected %h", tag, isr_o, 8'(want));
            end
        end
        s  = exp_sel();
        rd = isr_rd_i && (s != 7);
        @(posedge clk_i);
        if (!rst_ni) begin
            m_tx = 0; m_xoff = 0; m_spc = 0; m_flow = 0;
        end else begin
            m_tx   = tx_empty_i  | (m_tx   & !(rd && s == 3) & !tx_write_i);
            m_xoff = xoff_hit_i  | (m_xoff & !(rd && s == 5));
            m_spc  = spc_hit_i   | (m_spc  & !(rd && s == 5) & !rx_char_i);
            m_flow = flow_drop_i | (m_flow & !(rd && s == 6));
        end
        #1;
        tx_empty_i = 0; tx_write_i = 0; xoff_hit_i = 0; spc_hit_i = 0;
        flow_drop_i = 0; rx_char_i = 0; isr_rd_i = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        tx_empty_i = 1; flow_drop_i = 1;
        cyc("R1", 8'h01);
        cyc("R1", 8'h01);
        rst_ni = 1;
        cyc("R1", 8'h01);

        // R8: transmitter-empty flag set and cleared by read
        tx_empty_i = 1;   cyc("R8", 8'h01);
        cyc("R8", 8'h02);
        isr_rd_i = 1;     cyc("R8", 8'h02);
        cyc("R8", 8'h01);

        // R7: read while a level source is shown leaves the held flag alone
        rxrdy_req_i = 1; tx_empty_i = 1; cyc("R2", 8'h04);
        cyc("R2", 8'h04);
        isr_rd_i = 1;     cyc("R7", 8'h04);
        rxrdy_req_i = 0;  cyc("R7", 8'h02);
        tx_write_i = 1;   cyc("R8", 8'h02);
        cyc("R8", 8'h01);

        // R6 / R10: flow-control flag masked until efe rises
        efe_i = 0; flow_drop_i = 1; cyc("R6", 8'h01);
        cyc("R6", 8'h01);
        efe_i = 1;        cyc("R10", 8'h20);
        isr_rd_i = 1;     cyc("R10", 8'h20);
        cyc("R10", 8'h01);

        // R9: special character cleared by reception
        spc_hit_i = 1;    cyc("R9", 8'h01);
        cyc("R9", 8'h10);
        rx_char_i = 1;    cyc("R9", 8'h10);
        cyc("R9", 8'h01);

        // R9: Xoff match survives reception, cleared by read
        xoff_hit_i = 1;   cyc("R9", 8'h01);
        rx_char_i = 1;    cyc("R9", 8'h10);
        cyc("R9", 8'h10);
        isr_rd_i = 1;     cyc("R9", 8'h10);
        cyc("R9", 8'h01);

        // R11: set and clear in the same cycle
        tx_empty_i = 1;   cyc("R11", 8'h01);
        tx_empty_i = 1; tx_write_i = 1; isr_rd_i = 1; cyc("R11", 8'h02);
        cyc("R11", 8'h02);
        tx_write_i = 1;   cyc("R11", 8'h02);
        cyc("R11", 8'h01);

        // R3: FIFO-enable bits
        fifo_en_i = 1;    cyc("R3", 8'hC1);
        fifo_en_i = 0;

        // R5 / R2: enables and codes of the level sources
        src_en_i = 7'h00; line_req_i = 1; cyc("R5", 8'h01);
        src_en_i = 7'h7F; cyc("R2", 8'h06);
        line_req_i = 0; modem_req_i = 1; cyc("R2", 8'h00);
        rxto_req_i = 1;   cyc("R2", 8'h0C);
        rxto_req_i = 0; modem_req_i = 0; cyc("R2", 8'h01);

        // Random mix, every cycle checked against the model
        for (int n = 0; n < 4000; n++) begin
            if (n % 50 == 0) begin
                src_en_i  = 7'($urandom());
                efe_i     = 1'($urandom() % 4 != 0);
                fifo_en_i = 1'($urandom());
            end
            line_req_i  = ($urandom() % 8) == 0;
            rxto_req_i  = ($urandom() % 8) == 0;
            rxrdy_req_i = ($urandom() % 6) == 0;
            modem_req_i = ($urandom() % 8) == 0;
            tx_empty_i  = ($urandom() % 5) == 0;
            tx_write_i  = ($urandom() % 6) == 0;
            xoff_hit_i  = ($urandom() % 7) == 0;
            spc_hit_i   = ($urandom() % 7) == 0;
            flow_drop_i = ($urandom() % 7) == 0;
            rx_char_i   = ($urandom() % 4) == 0;
            isr_rd_i    = ($urandom() % 3) == 0;
            cyc("R2/R7");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule